// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Port

This block moves 24-bit stereo samples from a converter core onto a three-wire serial audio link. The core hands over a left/right pair in parallel with a one-cycle strobe. The port shifts each word out MSB first on a single data line, next to a bit clock and a frame clock that marks the left or right channel. Two framing styles can be chosen at run time: I2S, where the data starts one bit clock after the frame-clock edge, and left-justified, where the MSB sits on the first bit clock of the half-frame.

The port can own the link clocks or follow them. As clock master, it divides its own clock `clk` (256 times the sample rate) down to a 64-per-frame bit clock and a frame clock at the sample rate. As clock slave, it oversamples an external bit clock and frame clock, and it follows any ratio from 48 to 128 bits per frame. A pair is picked up only at the start of a left half-frame, so the two words of one frame always come from the same sampling instant. When no new pair has arrived, the previous pair is sent again.

Top module: `audio_ser_tx`

## Requirements
- R1: With `slave`=0 the port drives `bclk_o` with a period of 4 `clk` cycles and `lrck_o` with a period of 256 `clk` cycles (64 bit clocks per frame), and `clk_oe` is 1. With `slave`=1, `clk_oe` is 0.
- R2: Each 24-bit two's-complement word is sent MSB first, with all of its bits unchanged.
- R3: With `fmt_i2s`=0 (left-justified), the frame clock is high during the left half-frame, and the word's MSB occupies bit slot 0 of its half (the first bit clock after the frame-clock edge).
- R4: With `fmt_i2s`=1 (I2S), the frame clock is low during the left half-frame, and the word's MSB occupies bit slot 1 of its half, one bit clock after the edge.
- R5: Every bit slot of a half-frame that does not carry one of the 24 word bits outputs 0.
- R6: `sdata` changes only just after a falling edge of the bit clock. In master mode it changes on the same `clk` edge that makes `bclk_o` fall, so a receiver can capture it on the rising edge.
- R7: With `slave`=1, the port follows an external bit clock of 48, 64 or 128 bits per frame, taking the channel from `lrck_i`. The external bit clock must stay below `clk`/8.
- R8: In slave mode, a frame-clock edge starts a new word at bit slot 0 even when the current word is not finished. The word that was cut short is dropped from that point on.
- R9: A pair presented with `smp_vld` is latched at the start of the next left half-frame. A pair that arrives while a frame is in progress changes neither word of that frame.
- R10: When no new pair has arrived, the next frame repeats the previous pair.
- R11: While `pdn` is 1, `sdata` is 0 and the master bit clock is held low. After `pdn` is released, a pair supplied afterwards is sent normally.
- R12: While `rst_n` is 0, `sdata` is 0, `bclk_o` is 0, and `lrck_o` shows the left level of the left-justified format (1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Power-down: clears state and silences the line |
| fmt_i2s | input | 1 | 1 = I2S framing, 0 = left-justified |
| slave | input | 1 | 1 = clocks come from outside, 0 = port drives clocks |
| smp_l | input | 24 | Left sample, two's complement |
| smp_r | input | 24 | Right sample, two's complement |
| smp_vld | input | 1 | One-cycle strobe marking a new pair |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrck_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| lrck_o | output | 1 | Generated frame clock (master mode) |
| clk_oe | output | 1 | High when the generated clocks should drive the link |
| sdata | output | 1 | Serial audio data |

## Verification
The bench recovers words from the serial line the way a receiver would, sampling on each rising bit-clock edge. It then compares whole frames, so an off-by-one in the I2S delay, a word sent LSB first, or nonzero fill bits shows up as a frame that does not match. A new pair is injected in the middle of a left half-frame: a design that latched pairs immediately would send a right word from a different instant than the left. In slave mode, frames of 48 and 128 bits check that the port neither hangs nor wraps at an assumed 64. A frame clock that turns after only ten left bits catches a design that waits for the word to finish before starting the right channel. A power-down with all-ones data pending shows any leakage onto the line.

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
  parameter int DW = 24,
  parameter int MCLK_PER_BIT = 4,
  parameter int HALF_BITS = 32,
  parameter int SLOT_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pdn,
  input  logic          fmt_i2s,
  input  logic          slave,
  input  logic [DW-1:0] smp_l,
  input  logic [DW-1:0] smp_r,
  input  logic          smp_vld,
  input  logic          bclk_i,
  input  logic          lrck_i,
  output logic          bclk_o,
  output logic          lrck_o,
  output logic          clk_oe,
  output logic          sdata
);
  localparam int DVW = $clog2(MCLK_PER_BIT * 2 * HALF_BITS);
  localparam int PW  = $clog2(MCLK_PER_BIT);

  logic [DVW-1:0]    dv;
  logic              b1, b2, l1;
  logic [DW-1:0]     pend_l, pend_r, hold_l, hold_r;
  logic              prev_left, sd_q;
  logic [SLOT_W-1:0] slot;

  wire [DVW-1:0] dv_nx = dv + 1'b1;

  // one cycle before the master bit clock falls, or just after the slave one fell
  wire fall     = slave ? (b2 & ~b1) : (&dv[PW-1:0]);
  wire left_now = slave ? (l1 ^ fmt_i2s) : ~dv_nx[DVW-1];
  wire new_half = left_now != prev_left;

  wire [SLOT_W-1:0] slot_nx = new_half ? '0 : ((&slot) ? slot : slot + 1'b1);
  wire [SLOT_W:0]   idx     = {1'b0, slot_nx} - {{SLOT_W{1'b0}}, fmt_i2s};

  wire [DW-1:0] word_l = (new_half && left_now) ? pend_l : hold_l;
  wire [DW-1:0] word   = left_now ? word_l : hold_r;
  wire [DW-1:0] wsh    = word << idx;

  assign bclk_o = dv[PW-1];
  assign lrck_o = dv[DVW-1] ^ ~fmt_i2s;
  assign clk_oe = ~slave;
  assign sdata  = sd_q & ~pdn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv <= '0;
      {b1, b2, l1} <= 3'b110;
      {pend_l, pend_r, hold_l, hold_r} <= '0;
      prev_left <= 1'b1;
      slot <= '0;
      sd_q <= 1'b0;
    end else if (pdn) begin
      dv <= '0;
      {b1, b2, l1} <= 3'b110;
      {pend_l, pend_r, hold_l, hold_r} <= '0;
      prev_left <= 1'b1;
      slot <= '0;
      sd_q <= 1'b0;
    end else begin
      b1 <= bclk_i;
      b2 <= b1;
      l1 <= lrck_i;
      dv <= slave ? '0 : dv_nx;
      if (smp_vld) begin
        pend_l <= smp_l;
        pend_r <= smp_r;
      end
      if (fall) begin
        prev_left <= left_now;
        slot      <= slot_nx;
        sd_q      <= wsh[DW-1];
        if (new_half && left_now) begin
          hold_l <= pend_l;
          hold_r <= pend_r;
        end
      end
    end
  end
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic pdn,
  input logic slave,
  input logic fmt_i2s,
  input logic bclk_o,
  input logic lrck_o,
  input logic sdata
);
  a_r1_bclk_period: assert property (@(posedge clk) disable iff (!rst_n || pdn || slave)
    $rose(bclk_o) |=> bclk_o ##1 !bclk_o ##1 !bclk_o ##1 bclk_o);

  a_r1_lrck_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave && !pdn && !$past(pdn) && $stable(fmt_i2s) && !$stable(lrck_o)) |-> $fell(bclk_o));

  a_r6_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave && !$past(slave) && !pdn && !$past(pdn) && !$fell(bclk_o)) |-> $stable(sdata));

  a_r11_pdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn && $past(pdn)) |-> (!sdata && !bclk_o));
endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (.*);

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;
  logic clk = 0, rst_n = 0, pdn = 0, fmt = 0, slv = 0, vld = 0;
  logic bclk_i = 1, lrck_i = 0;
  logic [23:0] sl = '0, sr = '0;
  wire bclk_o, lrck_o, clk_oe, sdata;

  int nvec = 0, nbad = 0;
  logic g_prev = 1, g_cur = 1, last_b = 0;
  logic [127:0] cap;
  bit done = 0;

  audio_ser_tx u_audio_ser_tx (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .fmt_i2s(fmt), .slave(slv),
    .smp_l(sl), .smp_r(sr), .smp_vld(vld), .bclk_i(bclk_i), .lrck_i(lrck_i),
    .bclk_o(bclk_o), .lrck_o(lrck_o), .clk_oe(clk_oe), .sdata(sdata));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_pair(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk); sl = l; sr = r; vld = 1;
    @(negedge clk); vld = 0;
  endtask

  function automatic logic [127:0] exp_frame(int nl, int nr, logic f, logic [23:0] l, logic [23:0] r);
    logic [127:0] e = '0;
    int idx;
    for (int s = 0; s < nl + nr; s++) begin
      idx = ((s < nl) ? s : s - nl) - (f ? 1 : 0);
      if (idx >= 0 && idx < 24) e[s] = (s < nl) ? l[23-idx] : r[23-idx];
    end
    return e;
  endfunction

  task automatic m_bit();
    logic pb;
    pb = bclk_o;
    @(negedge clk);
    while (!(bclk_o && !pb)) begin
      pb = bclk_o;
      @(negedge clk);
    end
    g_prev = g_cur;
    g_cur  = lrck_o;
    last_b = sdata;
  endtask

  task automatic m_frame();
    logic ll;
    ll = ~fmt;
    cap = '0;
    m_bit();
    while (!(g_cur == ll && g_prev != ll)) m_bit();
    cap[0] = last_b;
    for (int i = 1; i < 64; i++) begin
      m_bit();
      cap[i] = last_b;
    end
  endtask

  task automatic s_frame(input int nl, input int nr);
    logic ll;
    ll = ~fmt;
    cap = '0;
    for (int i = 0; i < nl + nr; i++) begin
      @(negedge clk);
      bclk_i = 0;
      lrck_i = (i < nl) ? ll : ~ll;
      repeat (7) @(negedge clk);
      bclk_i = 1;
      cap[i] = sdata;
      repeat (7) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(sdata == 0, "R12 sdata in reset", 128'(sdata), 0);
    chk(bclk_o == 0, "R12 bclk_o in reset", 128'(bclk_o), 0);
    chk(lrck_o == 1, "R12 lrck_o in reset", 128'(lrck_o), 1);
    chk(clk_oe == 1, "R1 clk_oe master", 128'(clk_oe), 1);
  endtask

  task automatic t_rates();
    logic p, pb;
    int n, nb;
    p = lrck_o;
    @(negedge clk);
    while (!(lrck_o && !p)) begin p = lrck_o; @(negedge clk); end
    n = 0; nb = 0; pb = bclk_o; p = lrck_o;
    @(negedge clk); n++;
    while (!(lrck_o && !p)) begin
      if (bclk_o && !pb) nb++;
      pb = bclk_o; p = lrck_o;
      @(negedge clk); n++;
    end
    if (bclk_o && !pb) nb++;
    chk(n == 256, "R1 frame clock period", 128'(n), 256);
    chk(nb == 64, "R1 bit clocks per frame", 128'(nb), 64);
  endtask

  task automatic t_lj();
    put_pair(24'h9A3C5F, 24'h12E4B7);
    m_frame();
    chk(cap == exp_frame(32, 32, 0, 24'h9A3C5F, 24'h12E4B7), "R2/R3/R5 left-justified frame", cap, exp_frame(32, 32, 0, 24'h9A3C5F, 24'h12E4B7));
    m_frame();
    chk(cap == exp_frame(32, 32, 0, 24'h9A3C5F, 24'h12E4B7), "R10 repeated pair", cap, exp_frame(32, 32, 0, 24'h9A3C5F, 24'h12E4B7));
  endtask

  task automatic t_i2s();
    @(negedge clk); fmt = 1;
    put_pair(24'h800001, 24'h7FFFFE);
    m_frame();
    m_frame();
    chk(cap == exp_frame(32, 32, 1, 24'h800001, 24'h7FFFFE), "R4/R5 I2S frame", cap, exp_frame(32, 32, 1, 24'h800001, 24'h7FFFFE));
  endtask

  task automatic t_mid();
    m_frame();
    fork
      m_frame();
      begin repeat (40) @(negedge clk); put_pair(24'h5A5A5A, 24'hC3C3C3); end
    join
    chk(cap == exp_frame(32, 32, 1, 24'h800001, 24'h7FFFFE), "R9 frame unchanged by mid-frame pair", cap, exp_frame(32, 32, 1, 24'h800001, 24'h7FFFFE));
    m_frame();
    chk(cap == exp_frame(32, 32, 1, 24'h5A5A5A, 24'hC3C3C3), "R9 new pair next frame", cap, exp_frame(32, 32, 1, 24'h5A5A5A, 24'hC3C3C3));
  endtask

  task automatic t_edges();
    logic psd, pb;
    bit ok;
    ok = 1; psd = sdata; pb = bclk_o;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (sdata != psd && !(pb && !bclk_o)) ok = 0;
      psd = sdata; pb = bclk_o;
    end
    chk(ok, "R6 data changes only at bit clock fall", 128'(ok), 1);
  endtask

  task automatic t_pdn();
    bit ok;
    put_pair(24'hFFFFFF, 24'hFFFFFF);
    repeat (300) @(negedge clk);
    pdn = 1;
    @(negedge clk);
    ok = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sdata || bclk_o) ok = 0;
    end
    chk(ok, "R11 line quiet in power-down", 128'(ok), 1);
    pdn = 0;
    put_pair(24'h0F0F0F, 24'hF0F0F0);
    m_frame();
    m_frame();
    chk(cap == exp_frame(32, 32, 1, 24'h0F0F0F, 24'hF0F0F0), "R11 traffic after power-down", cap, exp_frame(32, 32, 1, 24'h0F0F0F, 24'hF0F0F0));
  endtask

  task automatic t_slave();
    @(negedge clk); slv = 1;
    @(negedge clk);
    chk(clk_oe == 0, "R1 clk_oe slave", 128'(clk_oe), 0);
    s_frame(32, 32);
    put_pair(24'hB16E05, 24'h4D2A91);
    s_frame(24, 24);
    chk(cap == exp_frame(24, 24, 1, 24'hB16E05, 24'h4D2A91), "R7 slave I2S 48 per frame", cap, exp_frame(24, 24, 1, 24'hB16E05, 24'h4D2A91));
    s_frame(64, 64);
    chk(cap == exp_frame(64, 64, 1, 24'hB16E05, 24'h4D2A91), "R7/R10 slave I2S 128 per frame", cap, exp_frame(64, 64, 1, 24'hB16E05, 24'h4D2A91));
    @(negedge clk); fmt = 0;
    s_frame(32, 32);
    put_pair(24'h3E8D10, 24'hE0071C);
    s_frame(64, 64);
    chk(cap == exp_frame(64, 64, 0, 24'h3E8D10, 24'hE0071C), "R7/R3 slave left-justified 128", cap, exp_frame(64, 64, 0, 24'h3E8D10, 24'hE0071C));
    put_pair(24'hA5F00F, 24'h6B29D4);
    s_frame(10, 32);
    chk(cap == exp_frame(10, 32, 0, 24'hA5F00F, 24'h6B29D4), "R8 short left half restarts word", cap, exp_frame(10, 32, 0, 24'hA5F00F, 24'h6B29D4));
    s_frame(32, 32);
    chk(cap == exp_frame(32, 32, 0, 24'hA5F00F, 24'h6B29D4), "R8 full frame after cut", cap, exp_frame(32, 32, 0, 24'hA5F00F, 24'h6B29D4));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_rates();
    t_lj();
    t_i2s();
    t_mid();
    t_edges();
    t_pdn();
    t_slave();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule